// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Engine

This block is the arithmetic core of a signal-processing datapath. It multiplies two 16-bit operands on a 17x17 signed multiplier and combines the result into one of two 40-bit accumulators. Each accumulator has eight guard bits above a 32-bit working range. The engine supports clear, plain and negated multiply, multiply-accumulate, multiply-subtract, squared difference with and without accumulation, and add, subtract and negate between the accumulators. Configuration pins select integer or fractional products, signed or unsigned operands, per-accumulator saturation with a narrow or wide limit, and the rounding applied to the 16-bit store value.

Commands arrive on a valid/ready interface. `in_ready` is low while reset is applied and rises at the first clock edge after reset is released. From then on the engine never applies back-pressure, so a command is accepted on every clock edge where `in_valid` is high. An accepted command updates its target accumulator at that same edge. The store value `wb_data` is a combinational view of the accumulator picked by `wb_sel`, rounded and optionally clamped.

Top module: `dsp_mac_engine`

## Requirements
- R1: During reset both accumulators read zero, both overflow flags are clear and `in_ready` is low. `in_ready` is high from the first rising edge after release and stays high.
- R2: An accumulator changes only at a rising edge where `in_valid` and `in_ready` are both high and `in_sel` selects it (0 = A, 1 = B).
- R3: MPY (op 1) loads `x*y`. The operands are zero-extended to 17 bits when `cfg_uns`=1 and sign-extended otherwise. When `cfg_int`=0 (fractional) the product is doubled.
- R4: MPYN (op 2) loads `-x*y`, MAC (op 3) adds `x*y` to the target and MSC (op 4) subtracts `x*y` from the target, using the same product as R3.
- R5: ED (op 5) loads `(x-y)^2` and EDAC (op 6) adds `(x-y)^2` to the target. The difference is taken on the extended operands, and the square is doubled in fractional mode.
- R6: CLR (op 0) loads zero. MOVSAC (op 7) leaves the target unchanged. ADD (op 8) loads A+B into the target. SUB (op 9) loads target minus other. NEG (op 10) loads minus target.
- R7: When saturation is enabled for the target (`cfg_sat_a` for A, `cfg_sat_b` for B) and `cfg_sat_wide`=0, the result is clamped to 0x007FFFFFFF / 0xFF80000000. The other accumulator's enable has no effect on the target.
- R8: With saturation enabled and `cfg_sat_wide`=1, the result is clamped to 0x7FFFFFFFFF / 0x8000000000.
- R9: With saturation disabled for the target, the result wraps modulo 2^40.
- R10: Each write sets the target's overflow flag (`ovf_a` / `ovf_b`) when the exact result lies outside the signed 32-bit range, and clears it otherwise. MOVSAC leaves the flag unchanged.
- R11: With `cfg_cnv`=0, `wb_data` is bits 31:16 of (selected accumulator + 0x8000).
- R12: With `cfg_cnv`=1 and low 16 bits exactly 0x8000, 0x8000 is added only when bit 16 is 1, so the result is even. Otherwise the behaviour is as in R11.
- R13: With `cfg_sat_wr`=1, a rounded value above 0x7FFFFFFF gives `wb_data`=0x7FFF, and one below -0x80000000 gives 0x8000.
- R14: Opcodes 11 to 15 change neither accumulator nor flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command valid |
| in_ready | output | 1 | Command ready |
| in_op | input | 4 | Opcode |
| in_sel | input | 1 | Target accumulator (0 = A, 1 = B) |
| in_x | input | 16 | Operand x |
| in_y | input | 16 | Operand y |
| cfg_int | input | 1 | 1 = integer product, 0 = fractional |
| cfg_uns | input | 1 | 1 = unsigned operands |
| cfg_cnv | input | 1 | 1 = convergent rounding |
| cfg_sat_a | input | 1 | Saturation enable, accumulator A |
| cfg_sat_b | input | 1 | Saturation enable, accumulator B |
| cfg_sat_wr | input | 1 | Clamp store value |
| cfg_sat_wide | input | 1 | 1 = 40-bit limit, 0 = 32-bit limit |
| wb_sel | input | 1 | Accumulator shown on wb_data |
| wb_data | output | 16 | Rounded store value |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_a | output | 1 | Overflow flag A |
| ovf_b | output | 1 | Overflow flag B |

## Verification
Accumulator and flag results are due at the rising edge that accepts the command. The bench drives each command on a falling edge and samples the accumulator and flag outputs on the next falling edge, which is one cycle later. The store value is combinational, so it is checked on the falling edge after the accumulator it depends on has been loaded and the rounding pins have been set. A command that must have no effect is issued the same way, and both accumulators are read on the next falling edge.

// File: rtl/dspmac_pkg.sv
package dspmac_pkg;
  typedef enum logic [3:0] {
    OP_CLR    = 4'd0,
    OP_MPY    = 4'd1,
    OP_MPYN   = 4'd2,
    OP_MAC    = 4'd3,
    OP_MSC    = 4'd4,
    OP_ED     = 4'd5,
    OP_EDAC   = 4'd6,
    OP_MOVSAC = 4'd7,
    OP_ADD    = 4'd8,
    OP_SUB    = 4'd9,
    OP_NEG    = 4'd10
  } mac_op_e;
endpackage

// File: rtl/dspmac_mult.sv
module dspmac_mult #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          int_i,
  input  logic          uns_i,
  output logic [AW-1:0] prod_o,
  output logic [AW-1:0] sq_o
);
  localparam int EW = DW + 1;
  localparam int PW = 2 * EW;
  localparam int SW = 2 * (EW + 1);

  logic signed [EW-1:0] xe, ye;
  logic signed [PW-1:0] p;
  logic signed [EW:0]   d;
  logic signed [SW-1:0] s;
  logic        [PW:0]   pf;
  logic        [SW:0]   sf;

  assign xe = uns_i ? $signed({1'b0, x_i}) : $signed({x_i[DW-1], x_i});
  assign ye = uns_i ? $signed({1'b0, y_i}) : $signed({y_i[DW-1], y_i});
  assign p  = xe * ye;
  assign d  = $signed({xe[EW-1], xe}) - $signed({ye[EW-1], ye});
  assign s  = d * d;

  assign pf = int_i ? {p[PW-1], p} : {p, 1'b0};
  assign sf = int_i ? {s[SW-1], s} : {s, 1'b0};

  assign prod_o = {{(AW-PW-1){pf[PW]}}, pf};
  assign sq_o   = {{(AW-SW-1){sf[SW]}}, sf};
endmodule

// File: rtl/dspmac_addsat.sv
module dspmac_addsat
  import dspmac_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic [3:0]    op_i,
  input  logic [AW-1:0] tgt_i,
  input  logic [AW-1:0] oth_i,
  input  logic [AW-1:0] prod_i,
  input  logic [AW-1:0] sq_i,
  input  logic          sat_en_i,
  input  logic          wide_i,
  output logic [AW-1:0] res_o,
  output logic          we_o,
  output logic          ovf_o
);
  localparam int XW = AW + 2;
  localparam int NW = 2 * DW;
  localparam logic signed [XW-1:0] N_MAX = {{(XW-NW+1){1'b0}}, {(NW-1){1'b1}}};
  localparam logic signed [XW-1:0] N_MIN = {{(XW-NW+1){1'b1}}, {(NW-1){1'b0}}};
  localparam logic signed [XW-1:0] W_MAX = {3'b000, {(AW-1){1'b1}}};
  localparam logic signed [XW-1:0] W_MIN = {3'b111, {(AW-1){1'b0}}};

  logic signed [XW-1:0] t, o, p, q, ex;

  assign t = $signed({{2{tgt_i[AW-1]}},  tgt_i});
  assign o = $signed({{2{oth_i[AW-1]}},  oth_i});
  assign p = $signed({{2{prod_i[AW-1]}}, prod_i});
  assign q = $signed({{2{sq_i[AW-1]}},   sq_i});

  always_comb begin
    we_o = 1'b1;
    ex   = t;
    case (op_i)
      OP_CLR:  ex = '0;
      OP_MPY:  ex = p;
      OP_MPYN: ex = -p;
      OP_MAC:  ex = t + p;
      OP_MSC:  ex = t - p;
      OP_ED:   ex = q;
      OP_EDAC: ex = t + q;
      OP_ADD:  ex = t + o;
      OP_SUB:  ex = t - o;
      OP_NEG:  ex = -t;
      default: we_o = 1'b0;
    endcase
  end

  assign ovf_o = (ex > N_MAX) || (ex < N_MIN);

  always_comb begin
    res_o = ex[AW-1:0];
    if (sat_en_i) begin
      if (wide_i) begin
        if (ex > W_MAX)      res_o = W_MAX[AW-1:0];
        else if (ex < W_MIN) res_o = W_MIN[AW-1:0];
      end else begin
        if (ex > N_MAX)      res_o = N_MAX[AW-1:0];
        else if (ex < N_MIN) res_o = N_MIN[AW-1:0];
      end
    end
  end
endmodule

// File: rtl/dspmac_round.sv
module dspmac_round #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic [AW-1:0] acc_i,
  input  logic          cnv_i,
  input  logic          sat_wr_i,
  output logic [DW-1:0] st_o
);
  localparam int RW = AW + 1;
  localparam int NW = 2 * DW;
  localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [RW-1:0] R_MAX = {{(RW-NW+1){1'b0}}, {(NW-1){1'b1}}};
  localparam logic signed [RW-1:0] R_MIN = {{(RW-NW+1){1'b1}}, {(NW-1){1'b0}}};

  logic            tie;
  logic [DW-1:0]   inc;
  logic signed [RW-1:0] r;

  assign tie = (acc_i[DW-1:0] == HALF);
  assign inc = (cnv_i && tie && !acc_i[DW]) ? '0 : HALF;
  assign r   = $signed({acc_i[AW-1], acc_i}) + $signed({{(RW-DW){1'b0}}, inc});

  always_comb begin
    st_o = r[NW-1:DW];
    if (sat_wr_i) begin
      if (r > R_MAX)      st_o = {1'b0, {(DW-1){1'b1}}};
      else if (r < R_MIN) st_o = {1'b1, {(DW-1){1'b0}}};
    end
  end
endmodule

// File: rtl/dsp_mac_engine.sv
module dsp_mac_engine
  import dspmac_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic          in_sel,
  input  logic [DW-1:0] in_x,
  input  logic [DW-1:0] in_y,
  input  logic          cfg_int,
  input  logic          cfg_uns,
  input  logic          cfg_cnv,
  input  logic          cfg_sat_a,
  input  logic          cfg_sat_b,
  input  logic          cfg_sat_wr,
  input  logic          cfg_sat_wide,
  input  logic          wb_sel,
  output logic [DW-1:0] wb_data,
  output logic [AW-1:0] acc_a,
  output logic [AW-1:0] acc_b,
  output logic          ovf_a,
  output logic          ovf_b
);
  localparam int NA = 2;
  localparam int NW = 2 * DW;
  localparam logic signed [AW-1:0] LIM_HI = {{(AW-NW+1){1'b0}}, {(NW-1){1'b1}}};
  localparam logic signed [AW-1:0] LIM_LO = {{(AW-NW+1){1'b1}}, {(NW-1){1'b0}}};

  logic [AW-1:0] acc_q [NA];
  logic [NA-1:0] ovf_q;
  logic [NA-1:0] sat_vec;
  logic          rdy_q, fire, we_c, ovf_c;
  logic [AW-1:0] prod_c, sq_c, res_c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;

  assign in_ready = rdy_q;
  assign fire     = in_valid && rdy_q;
  assign sat_vec  = {cfg_sat_b, cfg_sat_a};

  dspmac_mult #(.DW(DW), .AW(AW)) mult_i (
    .x_i(in_x), .y_i(in_y), .int_i(cfg_int), .uns_i(cfg_uns),
    .prod_o(prod_c), .sq_o(sq_c)
  );

  dspmac_addsat #(.DW(DW), .AW(AW)) addsat_i (
    .op_i(in_op), .tgt_i(acc_q[in_sel]), .oth_i(acc_q[~in_sel]),
    .prod_i(prod_c), .sq_i(sq_c), .sat_en_i(sat_vec[in_sel]),
    .wide_i(cfg_sat_wide), .res_o(res_c), .we_o(we_c), .ovf_o(ovf_c)
  );

  for (genvar i = 0; i < NA; i++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[i] <= '0;
        ovf_q[i] <= 1'b0;
      end else if (fire && (in_sel == i[0]) && we_c) begin
        acc_q[i] <= res_c;
        ovf_q[i] <= ovf_c;
      end
    end

    // R2: untouched unless an accepted command targets this accumulator
    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(fire && (in_sel == i[0])) |=> $stable(acc_q[i]));

    // R7: narrow saturation keeps the written value inside the 32-bit range
    assert_narrow_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (in_sel == i[0]) && we_c && sat_vec[i] && !cfg_sat_wide) |=>
      (($signed(acc_q[i]) <= LIM_HI) && ($signed(acc_q[i]) >= LIM_LO)));

    // R10: a clear leaves the flag low
    assert_ovf_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (in_sel == i[0]) && (in_op == OP_CLR)) |=> !ovf_q[i]);
  end

  // R1: once ready, ready stays high
  assert_ready_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  // R6: MOVSAC changes no accumulator
  assert_movsac_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_op == OP_MOVSAC)) |=> ($stable(acc_q[0]) && $stable(acc_q[1])));

  dspmac_round #(.DW(DW), .AW(AW)) round_i (
    .acc_i(acc_q[wb_sel]), .cnv_i(cfg_cnv), .sat_wr_i(cfg_sat_wr), .st_o(wb_data)
  );

  assign acc_a = acc_q[0];
  assign acc_b = acc_q[1];
  assign ovf_a = ovf_q[0];
  assign ovf_b = ovf_q[1];
endmodule

// File: tb/dsp_mac_engine_tb.sv
module dsp_mac_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic        in_sel = 1'b0;
  logic [15:0] in_x = '0, in_y = '0;
  logic        cfg_int = 0, cfg_uns = 0, cfg_cnv = 0, cfg_sat_a = 0,
               cfg_sat_b = 0, cfg_sat_wr = 0, cfg_sat_wide = 0, wb_sel = 0;
  logic [15:0] wb_data;
  logic [39:0] acc_a, acc_b;
  logic        ovf_a, ovf_b;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  dsp_mac_engine dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_sel(in_sel), .in_x(in_x), .in_y(in_y),
    .cfg_int(cfg_int), .cfg_uns(cfg_uns), .cfg_cnv(cfg_cnv),
    .cfg_sat_a(cfg_sat_a), .cfg_sat_b(cfg_sat_b), .cfg_sat_wr(cfg_sat_wr),
    .cfg_sat_wide(cfg_sat_wide), .wb_sel(wb_sel), .wb_data(wb_data),
    .acc_a(acc_a), .acc_b(acc_b), .ovf_a(ovf_a), .ovf_b(ovf_b)
  );

  // cfg field: {int, uns, sat_a, sat_b, wide}
  typedef struct packed {
    logic [3:0]  op;
    logic        sel;
    logic [15:0] x;
    logic [15:0] y;
    logic [4:0]  cfg;
    logic [39:0] exp_acc;
    logic        exp_ovf;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{4'd1,  1'b0, 16'h4000, 16'h4000, 5'b10000, 40'h0010000000, 1'b0}, // R3 int
    '{4'd1,  1'b0, 16'h4000, 16'h4000, 5'b00000, 40'h0020000000, 1'b0}, // R3 frac
    '{4'd1,  1'b0, 16'hFFFF, 16'h0003, 5'b10000, 40'hFFFFFFFFFD, 1'b0}, // R3 signed
    '{4'd1,  1'b0, 16'hFFFF, 16'h0003, 5'b11000, 40'h000002FFFD, 1'b0}, // R3 unsigned
    '{4'd3,  1'b0, 16'h0002, 16'h0005, 5'b10000, 40'h0000030007, 1'b0}, // R4 MAC
    '{4'd4,  1'b0, 16'h0001, 16'h0007, 5'b10000, 40'h0000030000, 1'b0}, // R4 MSC
    '{4'd2,  1'b1, 16'h0003, 16'h0004, 5'b10000, 40'hFFFFFFFFF4, 1'b0}, // R4 MPYN
    '{4'd5,  1'b0, 16'h000A, 16'h0003, 5'b10000, 40'h0000000031, 1'b0}, // R5 ED
    '{4'd6,  1'b0, 16'h0003, 16'h000A, 5'b10000, 40'h0000000062, 1'b0}, // R5 EDAC
    '{4'd5,  1'b0, 16'h8000, 16'h7FFF, 5'b00000, 40'h01FFFC0002, 1'b1}, // R5 frac, R10
    '{4'd8,  1'b1, 16'h0000, 16'h0000, 5'b00000, 40'h01FFFBFFF6, 1'b1}, // R6 ADD
    '{4'd9,  1'b0, 16'h0000, 16'h0000, 5'b00000, 40'h000000000C, 1'b0}, // R6 SUB
    '{4'd10, 1'b0, 16'h0000, 16'h0000, 5'b00000, 40'hFFFFFFFFF4, 1'b0}, // R6 NEG
    '{4'd7,  1'b0, 16'h1234, 16'h5678, 5'b00000, 40'hFFFFFFFFF4, 1'b0}, // R6 MOVSAC
    '{4'd0,  1'b1, 16'h0000, 16'h0000, 5'b00000, 40'h0000000000, 1'b0}, // R6 CLR
    '{4'd1,  1'b0, 16'h8000, 16'h8000, 5'b00100, 40'h007FFFFFFF, 1'b1}, // R7 clamp
    '{4'd1,  1'b0, 16'h8000, 16'h8000, 5'b00000, 40'h0080000000, 1'b1}  // R3 frac corner
  };

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called on a falling edge; returns on the next falling edge
  task automatic cmd(input logic [3:0] op, input logic sel, input logic [15:0] x,
                     input logic [15:0] y, input logic [4:0] c);
    in_op = op; in_sel = sel; in_x = x; in_y = y;
    {cfg_int, cfg_uns, cfg_sat_a, cfg_sat_b, cfg_sat_wide} = c;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {39'd0, in_ready}, 40'd0);
    chk("R1 acc_a reset", acc_a, 40'd0);
    chk("R1 acc_b reset", acc_b, 40'd0);
    chk("R1 flags reset", {38'd0, ovf_a, ovf_b}, 40'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {39'd0, in_ready}, 40'd1);

    for (int i = 0; i < NV; i++) begin
      cmd(TBL[i].op, TBL[i].sel, TBL[i].x, TBL[i].y, TBL[i].cfg);
      chk($sformatf("R3-R7 vector %0d acc", i), TBL[i].sel ? acc_b : acc_a, TBL[i].exp_acc);
      chk($sformatf("R10 vector %0d ovf", i), {39'd0, TBL[i].sel ? ovf_b : ovf_a},
          {39'd0, TBL[i].exp_ovf});
    end

    // R2: no accepted command, no change
    in_op = 4'd1; in_sel = 1'b0; in_x = 16'h0005; in_y = 16'h0005;
    @(negedge clk);
    chk("R2 idle keeps A", acc_a, 40'h0080000000);
    // R14: undefined opcode
    cmd(4'd12, 1'b0, 16'h0005, 16'h0005, 5'b10000);
    chk("R14 undefined op A", acc_a, 40'h0080000000);
    chk("R14 undefined op B", acc_b, 40'h0000000000);
    chk("R14 undefined op flag", {39'd0, ovf_a}, 40'd1);

    // R8/R9/R7 with large accumulators: B = 2^31
    cmd(4'd1, 1'b1, 16'h8000, 16'h8000, 5'b00000);
    for (int k = 0; k < 254; k++) cmd(4'd8, 1'b0, 16'h0, 16'h0, 5'b00000);
    chk("R9 accumulate below limit", acc_a, 40'h7F80000000);
    cmd(4'd8, 1'b0, 16'h0, 16'h0, 5'b00101);
    chk("R8 wide clamp", acc_a, 40'h7FFFFFFFFF);
    cmd(4'd8, 1'b0, 16'h0, 16'h0, 5'b00010);
    chk("R9 wrap, B enable ignored (R7)", acc_a, 40'h807FFFFFFF);
    cmd(4'd8, 1'b0, 16'h0, 16'h0, 5'b00100);
    chk("R7 narrow clamp negative", acc_a, 40'hFF80000000);

    // R11/R12 rounding
    cmd(4'd1, 1'b0, 16'h0001, 16'h8000, 5'b11000);
    cfg_cnv = 1'b0; #1;
    chk("R11 conventional tie even", {24'd0, wb_data}, 40'h0001);
    cfg_cnv = 1'b1; #1;
    chk("R12 convergent tie even", {24'd0, wb_data}, 40'h0000);
    cmd(4'd1, 1'b0, 16'h0003, 16'h8000, 5'b11000);
    chk("R12 convergent tie odd", {24'd0, wb_data}, 40'h0002);
    cfg_cnv = 1'b0; #1;
    chk("R11 conventional tie odd", {24'd0, wb_data}, 40'h0002);
    cfg_cnv = 1'b1;
    cmd(4'd3, 1'b0, 16'h0001, 16'h0001, 5'b11000);
    chk("R12 convergent above half", {24'd0, wb_data}, 40'h0002);
    cmd(4'd4, 1'b0, 16'h0001, 16'h0002, 5'b11000);
    chk("R12 convergent below half", {24'd0, wb_data}, 40'h0001);
    cfg_cnv = 1'b0;

    // R13 store clamp
    cmd(4'd1, 1'b0, 16'h8000, 16'h8000, 5'b00000);
    cfg_sat_wr = 1'b0; #1;
    chk("R13 positive unclamped", {24'd0, wb_data}, 40'h8000);
    cfg_sat_wr = 1'b1; #1;
    chk("R13 positive clamp", {24'd0, wb_data}, 40'h7FFF);
    cmd(4'd2, 1'b0, 16'h8000, 16'h8000, 5'b00000);
    chk("R13 in range negative", {24'd0, wb_data}, 40'h8000);
    cmd(4'd4, 1'b0, 16'h7FFF, 16'h7FFF, 5'b10000);
    chk("R4 MSC large", acc_a, 40'hFF4000FFFF);
    chk("R13 negative clamp", {24'd0, wb_data}, 40'h8000);
    cfg_sat_wr = 1'b0; #1;
    chk("R13 negative unclamped", {24'd0, wb_data}, 40'h4001);
    wb_sel = 1'b1; cfg_sat_wr = 1'b1; #1;
    chk("R13 store from B", {24'd0, wb_data}, 40'h7FFF);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule